// File: doc/BRIEF.md
# Banked Maskable Interrupt Controller

This block collects 96 level-sensitive interrupt lines and presents two request wires to a processor: a normal request and a fast request. Sources are grouped in three 32-bit mask banks. Each source has its own level word that chooses whether it feeds the normal or the fast path and carries a small priority value. Software controls everything through a simple 32-bit synchronous read/write port.

Each path has its own arbiter. The arbiter looks at sources that are pending, unmasked and steered to that path. When a winner exists, its number is latched and the request wire rises. The number then stays frozen, whatever the sources do, until software writes the re-arm bit for that path in the control word. The next arbitration starts the cycle after that write. Masks are changed through write-one-to-set and write-one-to-clear aliases, so software never needs a read-modify-write.

Register map (byte offsets): normal vector 0x40, fast vector 0x44, control 0x48. Control bit 0 re-arms the normal path and bit 1 re-arms the fast path. For each bank b: direct mask 0x84+0x20*b, clear alias 0x88+0x20*b, set alias 0x8C+0x20*b. The level word of source n is at 0x100+4*n. In a vector word, bits 6:0 hold the winning source number and bit 7 flags that no winner is held.

Top module: `banked_irq_ctrl`

## Requirements
- R1: After reset every mask bit reads 1 (each direct mask word reads 0xFFFFFFFF), every level word reads 0, and both irq_o and fiq_o are low.
- R2: Writing the clear alias of a bank sets to 0 exactly the mask bits written as 1. Writing the set alias sets to 1 exactly the mask bits written as 1. Bits written as 0 keep their value. All three addresses of a bank read back the current mask.
- R3: A write to a bank's direct mask word replaces the whole bank. Writing 0xFFFFFFFF to all three banks blocks every source: no request rises even with all 96 sources high.
- R4: Source n is governed by bank n/32, bit n%32 (a mask bit of 1 blocks the source).
- R5: Level word bit 0 is the fast-steer bit and bits 7:2 are a priority value. Among eligible sources, the lowest priority value wins, and a tie goes to the lowest source number.
- R6: A source whose fast-steer bit is 1 never takes part in normal arbitration. It raises fiq_o, and the fast vector word reports its number.
- R7: Once a request is high, its latched number and the request itself stay unchanged until the matching re-arm bit is written. This holds when the winning source drops and when a better source appears.
- R8: A control write with the re-arm bit drops the matching request in the cycle after the write. If an eligible source exists, the request is raised again one cycle later with the new winner.
- R9: While a path holds no winner, its request is low and its vector word reads 0x80.
- R10: Read data appears on bus_rdata in the cycle after the read strobe. Writes take effect at the clock edge that samples them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and logic clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | 12 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| src_i | input | 96 | Level-sensitive interrupt lines, synchronous to clk |
| irq_o | output | 1 | Normal interrupt request |
| fiq_o | output | 1 | Fast interrupt request |

## Verification
A corrupted mask or level bit shows up as the wrong source number in a vector word, or as a request that rises or stays low against expectation. This appears two cycles after the source and mask settle, because the latch sits behind one register. A latch that fails to hold shows as a vector number that changes before the re-arm write. A latch that fails to re-arm shows as a request still high one cycle after that write. The bench sets up cases where priority and source number disagree, so that a wrong winner is visible at once in the vector word.

// File: rtl/irq_ctrl_pkg.sv
package irq_ctrl_pkg;
  localparam int unsigned OFS_ACT_IRQ   = 'h040;
  localparam int unsigned OFS_ACT_FIQ   = 'h044;
  localparam int unsigned OFS_CTRL      = 'h048;
  localparam int unsigned OFS_MASK_BASE = 'h084;
  localparam int unsigned OFS_MCLR_BASE = 'h088;
  localparam int unsigned OFS_MSET_BASE = 'h08C;
  localparam int unsigned BANK_STRIDE   = 'h020;
  localparam int unsigned OFS_LVL_BASE  = 'h100;
  localparam int unsigned SPUR_BIT      = 7;
  localparam int unsigned CTRL_REARM_IRQ = 0;
  localparam int unsigned CTRL_REARM_FIQ = 1;
  localparam int unsigned LVL_FIQ_BIT   = 0;
  localparam int unsigned LVL_PRIO_LSB  = 2;
endpackage

// File: rtl/irq_mask_bank.sv
module irq_mask_bank #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr_dir,
  input  logic         wr_set,
  input  logic         wr_clr,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] mask_o
);
  always_ff @(posedge clk) begin
    if (rst)         mask_o <= '1;
    else if (wr_dir) mask_o <= wdata;
    else if (wr_set) mask_o <= mask_o | wdata;
    else if (wr_clr) mask_o <= mask_o & ~wdata;
  end
endmodule

// File: rtl/irq_level_file.sv
module irq_level_file #(
  parameter int N      = 96,
  parameter int PRIO_W = 6,
  parameter int IDX_W  = 7
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  wr_en,
  input  logic [IDX_W-1:0]      wr_idx,
  input  logic                  wr_fiq,
  input  logic [PRIO_W-1:0]     wr_prio,
  output logic [N-1:0]          steer_o,
  output logic [N*PRIO_W-1:0]   prio_o
);
  for (genvar i = 0; i < N; i++) begin : g_ent
    always_ff @(posedge clk) begin
      if (rst) begin
        steer_o[i]                 <= 1'b0;
        prio_o[i*PRIO_W +: PRIO_W] <= '0;
      end else if (wr_en && wr_idx == IDX_W'(i)) begin
        steer_o[i]                 <= wr_fiq;
        prio_o[i*PRIO_W +: PRIO_W] <= wr_prio;
      end
    end
  end
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter #(
  parameter int N      = 96,
  parameter int PRIO_W = 6,
  parameter int IDX_W  = 7
) (
  input  logic [N-1:0]        elig,
  input  logic [N*PRIO_W-1:0] prio,
  output logic                found,
  output logic [IDX_W-1:0]    idx
);
  logic [PRIO_W-1:0] best;

  always_comb begin
    found = 1'b0;
    idx   = '0;
    best  = '1;
    for (int i = N - 1; i >= 0; i--) begin
      if (elig[i] && (!found || prio[i*PRIO_W +: PRIO_W] <= best)) begin
        found = 1'b1;
        best  = prio[i*PRIO_W +: PRIO_W];
        idx   = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/irq_vector_latch.sv
module irq_vector_latch #(
  parameter int IDX_W = 7
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rearm,
  input  logic             found,
  input  logic [IDX_W-1:0] idx,
  output logic             req_o,
  output logic [IDX_W-1:0] vec_o
);
  always_ff @(posedge clk) begin
    if (rst) begin
      req_o <= 1'b0;
      vec_o <= '0;
    end else if (rearm) begin
      req_o <= 1'b0;
    end else if (!req_o && found) begin
      req_o <= 1'b1;
      vec_o <= idx;
    end
  end
endmodule

// File: rtl/banked_irq_ctrl.sv
module banked_irq_ctrl
  import irq_ctrl_pkg::*;
#(
  parameter int NUM_SRC = 96,
  parameter int DATA_W  = 32,
  parameter int PRIO_W  = 6,
  parameter int ADDR_W  = 12
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               bus_wr,
  input  logic               bus_rd,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic [DATA_W-1:0]  bus_wdata,
  output logic [DATA_W-1:0]  bus_rdata,
  input  logic [NUM_SRC-1:0] src_i,
  output logic               irq_o,
  output logic               fiq_o
);
  localparam int NUM_BANK = NUM_SRC / DATA_W;
  localparam int IDX_W    = $clog2(NUM_SRC);
  localparam logic [ADDR_W-1:0] LVL_BASE = ADDR_W'(OFS_LVL_BASE);
  localparam logic [ADDR_W-1:0] LVL_END  = ADDR_W'(OFS_LVL_BASE + 4 * NUM_SRC);

  logic [DATA_W-1:0]         bank_mask [NUM_BANK];
  logic [NUM_SRC-1:0]        mask_flat;
  logic [NUM_SRC-1:0]        steer;
  logic [NUM_SRC*PRIO_W-1:0] prio_flat;
  logic [NUM_SRC-1:0]        irq_elig, fiq_elig;
  logic                      irq_found, fiq_found;
  logic [IDX_W-1:0]          irq_idx, fiq_idx;
  logic                      irq_req, fiq_req;
  logic [IDX_W-1:0]          irq_vec, fiq_vec;
  logic                      rearm_irq, rearm_fiq;
  logic                      in_lvl;
  logic [IDX_W-1:0]          lvl_idx;
  logic [DATA_W-1:0]         act_irq_word, act_fiq_word;
  logic [DATA_W-1:0]         rd_mux;

  // mask banks
  for (genvar b = 0; b < NUM_BANK; b++) begin : g_bank
    localparam logic [ADDR_W-1:0] A_DIR = ADDR_W'(OFS_MASK_BASE + b * BANK_STRIDE);
    localparam logic [ADDR_W-1:0] A_CLR = ADDR_W'(OFS_MCLR_BASE + b * BANK_STRIDE);
    localparam logic [ADDR_W-1:0] A_SET = ADDR_W'(OFS_MSET_BASE + b * BANK_STRIDE);
    irq_mask_bank #(.W(DATA_W)) u_bank (
      .clk    (clk),
      .rst    (rst),
      .wr_dir (bus_wr && bus_addr == A_DIR),
      .wr_set (bus_wr && bus_addr == A_SET),
      .wr_clr (bus_wr && bus_addr == A_CLR),
      .wdata  (bus_wdata),
      .mask_o (bank_mask[b])
    );
    assign mask_flat[b*DATA_W +: DATA_W] = bank_mask[b];
  end

  // level words
  assign in_lvl  = (bus_addr >= LVL_BASE) && (bus_addr < LVL_END) && (bus_addr[1:0] == 2'b00);
  assign lvl_idx = IDX_W'((bus_addr - LVL_BASE) >> 2);

  irq_level_file #(.N(NUM_SRC), .PRIO_W(PRIO_W), .IDX_W(IDX_W)) u_lvl (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (bus_wr && in_lvl),
    .wr_idx  (lvl_idx),
    .wr_fiq  (bus_wdata[LVL_FIQ_BIT]),
    .wr_prio (bus_wdata[LVL_PRIO_LSB +: PRIO_W]),
    .steer_o (steer),
    .prio_o  (prio_flat)
  );

  // eligibility and arbitration per path
  assign irq_elig = src_i & ~mask_flat & ~steer;
  assign fiq_elig = src_i & ~mask_flat & steer;

  irq_arbiter #(.N(NUM_SRC), .PRIO_W(PRIO_W), .IDX_W(IDX_W)) u_arb_irq (
    .elig (irq_elig), .prio (prio_flat), .found (irq_found), .idx (irq_idx)
  );
  irq_arbiter #(.N(NUM_SRC), .PRIO_W(PRIO_W), .IDX_W(IDX_W)) u_arb_fiq (
    .elig (fiq_elig), .prio (prio_flat), .found (fiq_found), .idx (fiq_idx)
  );

  assign rearm_irq = bus_wr && bus_addr == ADDR_W'(OFS_CTRL) && bus_wdata[CTRL_REARM_IRQ];
  assign rearm_fiq = bus_wr && bus_addr == ADDR_W'(OFS_CTRL) && bus_wdata[CTRL_REARM_FIQ];

  irq_vector_latch #(.IDX_W(IDX_W)) u_hold_irq (
    .clk (clk), .rst (rst), .rearm (rearm_irq), .found (irq_found),
    .idx (irq_idx), .req_o (irq_req), .vec_o (irq_vec)
  );
  irq_vector_latch #(.IDX_W(IDX_W)) u_hold_fiq (
    .clk (clk), .rst (rst), .rearm (rearm_fiq), .found (fiq_found),
    .idx (fiq_idx), .req_o (fiq_req), .vec_o (fiq_vec)
  );

  assign irq_o = irq_req;
  assign fiq_o = fiq_req;

  // vector words
  always_comb begin
    act_irq_word = '0;
    act_fiq_word = '0;
    if (irq_req) act_irq_word[IDX_W-1:0] = irq_vec;
    else         act_irq_word[SPUR_BIT]  = 1'b1;
    if (fiq_req) act_fiq_word[IDX_W-1:0] = fiq_vec;
    else         act_fiq_word[SPUR_BIT]  = 1'b1;
  end

  // read mux
  always_comb begin
    rd_mux = '0;
    if (bus_addr == ADDR_W'(OFS_ACT_IRQ)) rd_mux = act_irq_word;
    if (bus_addr == ADDR_W'(OFS_ACT_FIQ)) rd_mux = act_fiq_word;
    for (int b = 0; b < NUM_BANK; b++) begin
      if (bus_addr == ADDR_W'(OFS_MASK_BASE + b * BANK_STRIDE) ||
          bus_addr == ADDR_W'(OFS_MCLR_BASE + b * BANK_STRIDE) ||
          bus_addr == ADDR_W'(OFS_MSET_BASE + b * BANK_STRIDE))
        rd_mux = bank_mask[b];
    end
    if (in_lvl) begin
      rd_mux[LVL_FIQ_BIT]               = steer[lvl_idx];
      rd_mux[LVL_PRIO_LSB +: PRIO_W]    = prio_flat[lvl_idx*PRIO_W +: PRIO_W];
    end
  end

  always_ff @(posedge clk) begin
    if (rst)         bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rd_mux;
  end
endmodule

// File: rtl/irq_ctrl_chk.sv
module irq_ctrl_chk #(
  parameter int N     = 96,
  parameter int IDX_W = 7
) (
  input logic             clk,
  input logic             rst,
  input logic             irq_o,
  input logic             fiq_o,
  input logic             rearm_irq,
  input logic             rearm_fiq,
  input logic [IDX_W-1:0] irq_vec,
  input logic [IDX_W-1:0] fiq_vec,
  input logic [N-1:0]     src_i,
  input logic [N-1:0]     mask_flat,
  input logic [N-1:0]     steer,
  input logic [31:0]      act_irq_word
);
  logic [N-1:0] mask_q, steer_q, src_q;

  always_ff @(posedge clk) begin
    mask_q  <= mask_flat;
    steer_q <= steer;
    src_q   <= src_i;
  end

  a_r1_reset_quiet: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (!irq_o && !fiq_o));

  // R4 and R5: a latched normal winner was pending and unmasked
  a_r5_winner_eligible: assert property (@(posedge clk) disable iff (rst)
    $rose(irq_o) |-> (src_q[irq_vec] && !mask_q[irq_vec]));

  a_r6_fast_not_normal: assert property (@(posedge clk) disable iff (rst)
    $rose(irq_o) |-> !steer_q[irq_vec]);

  a_r6_fast_steered: assert property (@(posedge clk) disable iff (rst)
    $rose(fiq_o) |-> steer_q[fiq_vec]);

  a_r7_hold_irq: assert property (@(posedge clk) disable iff (rst)
    (irq_o && !rearm_irq) |=> (irq_o && $stable(irq_vec)));

  a_r7_hold_fiq: assert property (@(posedge clk) disable iff (rst)
    (fiq_o && !rearm_fiq) |=> (fiq_o && $stable(fiq_vec)));

  a_r8_rearm_drop: assert property (@(posedge clk) disable iff (rst)
    rearm_irq |=> !irq_o);

  a_r9_spurious_flag: assert property (@(posedge clk) disable iff (rst)
    !irq_o |-> (act_irq_word == 32'h80));
endmodule

bind banked_irq_ctrl irq_ctrl_chk #(.N(NUM_SRC), .IDX_W(IDX_W)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .irq_o        (irq_o),
  .fiq_o        (fiq_o),
  .rearm_irq    (rearm_irq),
  .rearm_fiq    (rearm_fiq),
  .irq_vec      (irq_vec),
  .fiq_vec      (fiq_vec),
  .src_i        (src_i),
  .mask_flat    (mask_flat),
  .steer        (steer),
  .act_irq_word (act_irq_word)
);

// File: tb/tb_banked_irq_ctrl.sv
module tb_banked_irq_ctrl;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [95:0] src = '0;
  logic        irq_o, fiq_o;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  always #10 clk = ~clk;

  banked_irq_ctrl dut (
    .clk (clk), .rst (rst), .bus_wr (bus_wr), .bus_rd (bus_rd),
    .bus_addr (bus_addr), .bus_wdata (bus_wdata), .bus_rdata (bus_rdata),
    .src_i (src), .irq_o (irq_o), .fiq_o (fiq_o)
  );

  // a, b, prio a, prio b, expected winner
  localparam logic [32:0] VEC [7] = '{
    {7'd5,  7'd9,  6'd0,  6'd0,  7'd5},
    {7'd9,  7'd5,  6'd3,  6'd1,  7'd5},
    {7'd40, 7'd2,  6'd0,  6'd7,  7'd40},
    {7'd95, 7'd64, 6'd2,  6'd2,  7'd64},
    {7'd33, 7'd94, 6'd10, 6'd4,  7'd94},
    {7'd0,  7'd31, 6'd63, 6'd62, 7'd31},
    {7'd63, 7'd32, 6'd1,  6'd1,  7'd32}
  };

  function automatic logic [11:0] a_mask(int b); return 12'(32'h84 + 32 * b); endfunction
  function automatic logic [11:0] a_mclr(int b); return 12'(32'h88 + 32 * b); endfunction
  function automatic logic [11:0] a_mset(int b); return 12'(32'h8C + 32 * b); endfunction
  function automatic logic [11:0] a_lvl(int n);  return 12'(32'h100 + 4 * n); endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic wait2();
    @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset state, R9 spurious flag, R10 read latency
    chk("R1 irq_o low", 32'(irq_o), 0);
    chk("R1 fiq_o low", 32'(fiq_o), 0);
    for (int b = 0; b < 3; b++) begin
      rd(a_mask(b), d);
      chk("R1 mask all ones", d, 32'hFFFF_FFFF);
    end
    rd(a_lvl(50), d);
    chk("R1 level zero", d, 0);
    rd(12'h040, d);
    chk("R9 spurious after reset", d, 32'h80);

    // R2 alias semantics
    wr(a_mclr(0), 32'h0000_0011);
    rd(a_mask(0), d);
    chk("R2 clear alias", d, 32'hFFFF_FFEE);
    wr(a_mset(0), 32'h0000_0010);
    rd(a_mset(0), d);
    chk("R2 set alias", d, 32'hFFFF_FFFE);
    wr(a_mask(0), 32'hFFFF_FFFF);

    // R5 level field layout readback
    wr(a_lvl(5), 32'h0C);
    rd(a_lvl(5), d);
    chk("R5 level readback", d, 32'h0C);
    wr(a_lvl(5), 32'h0);

    // R5 table walk: priority first, then lowest number
    foreach (VEC[k]) begin
      int a, b, ex;
      logic [5:0] pa, pb;
      a  = int'(VEC[k][32:26]);
      b  = int'(VEC[k][25:19]);
      pa = VEC[k][18:13];
      pb = VEC[k][12:7];
      ex = int'(VEC[k][6:0]);
      wr(a_lvl(a), {24'd0, pa, 2'b00});
      wr(a_lvl(b), {24'd0, pb, 2'b00});
      wr(a_mclr(a / 32), 32'(1) << (a % 32));
      wr(a_mclr(b / 32), 32'(1) << (b % 32));
      src[a] = 1'b1; src[b] = 1'b1;
      wait2();
      chk("R5 table irq_o", 32'(irq_o), 1);
      rd(12'h040, d);
      chk("R5 table winner", d, 32'(ex));
      src = '0;
      wr(a_mask(a / 32), 32'hFFFF_FFFF);
      wr(a_mask(b / 32), 32'hFFFF_FFFF);
      wr(a_lvl(a), 0);
      wr(a_lvl(b), 0);
      wr(12'h048, 32'h1);
    end
    @(negedge clk);
    rd(12'h040, d);
    chk("R9 spurious after table", d, 32'h80);

    // R4 mapping: source 37 is bank 1 bit 5
    wr(a_mclr(1), 32'h20);
    rd(a_mask(1), d);
    chk("R4 bank1 mask", d, 32'hFFFF_FFDF);
    src[37] = 1'b1;
    wait2();
    rd(12'h040, d);
    chk("R4 source 37 vector", d, 32'd37);
    // R8 rearm with source still high
    wr(12'h048, 32'h1);
    chk("R8 drop after rearm", 32'(irq_o), 0);
    @(negedge clk);
    chk("R8 reassert", 32'(irq_o), 1);
    rd(12'h040, d);
    chk("R8 new winner", d, 32'd37);
    // R3 direct write replaces bank
    wr(a_mask(1), 32'hFFFF_FFFF);
    wr(12'h048, 32'h1);
    wait2();
    chk("R3 masked no irq", 32'(irq_o), 0);
    rd(12'h040, d);
    chk("R9 spurious when masked", d, 32'h80);
    src = '0;

    // R3 global disable with all sources high
    for (int b = 0; b < 3; b++) wr(a_mclr(b), 32'hFFFF_FFFF);
    for (int b = 0; b < 3; b++) wr(a_mask(b), 32'hFFFF_FFFF);
    src = '1;
    wait2();
    chk("R3 all masked irq", 32'(irq_o), 0);
    chk("R3 all masked fiq", 32'(fiq_o), 0);
    src = '0;

    // R7 hold, R8 rearm to new winner
    wr(a_mclr(0), 32'h0000_0408);
    src[10] = 1'b1;
    wait2();
    rd(12'h040, d);
    chk("R7 first latch", d, 32'd10);
    src[3] = 1'b1;
    wait2();
    rd(12'h040, d);
    chk("R7 held vs better source", d, 32'd10);
    src[10] = 1'b0;
    wait2();
    chk("R7 request held", 32'(irq_o), 1);
    rd(12'h040, d);
    chk("R7 held after drop", d, 32'd10);
    wr(12'h048, 32'h1);
    chk("R8 drop cycle", 32'(irq_o), 0);
    @(negedge clk);
    chk("R8 rise cycle", 32'(irq_o), 1);
    rd(12'h040, d);
    chk("R8 rearm winner", d, 32'd3);
    src = '0;
    wr(a_mask(0), 32'hFFFF_FFFF);
    wr(12'h048, 32'h1);

    // R6 fast steering
    wr(a_lvl(70), 32'h1);
    rd(a_lvl(70), d);
    chk("R6 level steer bit", d, 32'h1);
    wr(a_mclr(2), 32'hC0);
    src[70] = 1'b1;
    wait2();
    chk("R6 fiq_o high", 32'(fiq_o), 1);
    chk("R6 irq_o low", 32'(irq_o), 0);
    rd(12'h044, d);
    chk("R6 fast vector", d, 32'd70);
    rd(12'h040, d);
    chk("R6 normal spurious", d, 32'h80);
    src[71] = 1'b1;
    wait2();
    rd(12'h040, d);
    chk("R6 normal picks 71", d, 32'd71);
    wr(12'h048, 32'h2);
    chk("R8 fast rearm drop", 32'(fiq_o), 0);
    chk("R8 normal unaffected", 32'(irq_o), 1);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule